// File: doc/BRIEF.md
# Pin Bank Controller with Edge Interrupts

A register-programmed bank of general-purpose pins on an APB slave port. The bank width is a parameter from 1 to 32. Software sets each pin's output value and output enable. It chooses, pin by pin, whether the pad output comes from the output register or from an auxiliary signal supplied by another on-chip block. The output value and enable vectors go to external tri-state or open-drain pad cells.

Pin inputs are captured into a readable input register. Capture happens on every system clock edge, or, when the `USE_EXT_CLK` parameter is set, on a chosen edge of an external sampling clock. In that mode the pins and the external clock each pass through two flops before use. The captured input feeds per-pin edge detection. An input pin whose interrupt is enabled and whose selected edge appears latches a sticky status bit. Software clears a status bit by writing 1 to it. A single interrupt line rises while the global enable is set and any status bit is set.

The APB port has no wait states: PREADY is held high. A transfer to an address outside the map completes with PSLVERR.

Top module: `pin_bank_apb`

## Requirements
- R1: After reset every per-pin register, the control register and the status register read zero, `pad_oe_o` is all zeros (every pin an input) and `irq_o` is low.
- R2: Offsets 0x04 output value, 0x08 output enable, 0x0C interrupt enable, 0x10 edge select and 0x14 auxiliary select each store the low `PINS` bits of a write and read them back, with bits at and above `PINS` reading zero.
- R3: For each pin, `pad_out_o` equals `aux_i` when the auxiliary-select bit is 1 and the output-value bit when it is 0.
- R4: `pad_oe_o` equals the output-enable register.
- R5: Offset 0x00 reads the captured pins. With system-clock capture, a pin change is readable after one rising edge. A write to 0x00 has no effect.
- R6: An edge-select bit of 1 latches status on a rising captured edge of that pin, and a bit of 0 latches status on a falling edge. Status at offset 0x1C is readable two rising edges after the pin change.
- R7: A pin latches status only while its interrupt-enable bit is 1 and its output-enable bit is 0.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it. A new event in the same cycle as a clear of the same bit leaves the bit set.
- R9: Control offset 0x18 has bit 0 as the global interrupt enable and bit 1 as a sticky pending flag. The pending flag sets whenever any status bit newly latches and clears when written 0. `irq_o` is high exactly when bit 0 is 1 and any status bit is 1.
- R10: PREADY is always high. A transfer whose address is not one of the eight word offsets 0x00 to 0x1C raises PSLVERR in its access phase and changes no register.
- R11: With `USE_EXT_CLK` set, the input register changes only after a rising edge of `ext_clk_i` (a falling edge when `EXT_FALL` is set). The external clock and the pins each pass through two system-clock flops first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write when high |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, constant high |
| pslverr_o | output | 1 | APB error for unmapped address |
| pins_i | input | PINS | Pad input values |
| ext_clk_i | input | 1 | External sampling clock |
| aux_i | input | PINS | Auxiliary output sources |
| pad_out_o | output | PINS | Pad output values |
| pad_oe_o | output | PINS | Pad output enables |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupted register bit shows at `pad_out_o` or `pad_oe_o` in the cycle after the write. The pad mux is compared against a bench model after every random write, so such a fault appears within one transfer. A wrong edge history or a wrong mask shows as an extra or a missing status bit two edges after a pin change. It also shows as `irq_o` disagreeing with the enable and status readback. A broken clear, or a clear that beats a concurrent event, shows on the next read of offset 0x1C.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
  localparam int DATA_W = 32;

  // Word index of each register (byte address bits [4:2])
  typedef enum logic [2:0] {
    RG_IN   = 3'd0,
    RG_OUT  = 3'd1,
    RG_OE   = 3'd2,
    RG_IE   = 3'd3,
    RG_TRIG = 3'd4,
    RG_AUX  = 3'd5,
    RG_CTRL = 3'd6,
    RG_STS  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/pin_bank_regs.sv
module pin_bank_regs
  import pin_bank_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pslverr_o,
  input  logic [PINS-1:0]   in_q_i,
  input  logic [PINS-1:0]   sts_q_i,
  input  logic              pend_q_i,
  output logic [PINS-1:0]   out_q_o,
  output logic [PINS-1:0]   oe_q_o,
  output logic [PINS-1:0]   ie_q_o,
  output logic [PINS-1:0]   trig_q_o,
  output logic [PINS-1:0]   sel_q_o,
  output logic              gie_q_o,
  output logic [PINS-1:0]   sts_clr_o,
  output logic              pend_wr_o,
  output logic              pend_wval_o
);
  localparam int IDX_LSB = 2;
  localparam int IDX_MSB = 4;

  logic     hit, access, wr_en;
  reg_sel_e rsel;
  logic [DATA_W-1:0] rd_word;
  logic unused_wdata;

  assign rsel   = reg_sel_e'(paddr_i[IDX_MSB:IDX_LSB]);
  assign hit    = (paddr_i[IDX_LSB-1:0] == '0) && (paddr_i[ADDR_W-1:IDX_MSB+1] == '0);
  assign access = psel_i & penable_i;
  assign wr_en  = access & pwrite_i & hit;
  assign unused_wdata = ^pwdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q_o  <= '0;
      oe_q_o   <= '0;
      ie_q_o   <= '0;
      trig_q_o <= '0;
      sel_q_o  <= '0;
      gie_q_o  <= 1'b0;
    end else if (wr_en) begin
      case (rsel)
        RG_OUT:  out_q_o  <= pwdata_i[PINS-1:0];
        RG_OE:   oe_q_o   <= pwdata_i[PINS-1:0];
        RG_IE:   ie_q_o   <= pwdata_i[PINS-1:0];
        RG_TRIG: trig_q_o <= pwdata_i[PINS-1:0];
        RG_AUX:  sel_q_o  <= pwdata_i[PINS-1:0];
        RG_CTRL: gie_q_o  <= pwdata_i[0];
        default: ;
      endcase
    end
  end

  assign sts_clr_o   = (wr_en && rsel == RG_STS) ? pwdata_i[PINS-1:0] : '0;
  assign pend_wr_o   = wr_en && (rsel == RG_CTRL);
  assign pend_wval_o = pwdata_i[1];

  always_comb begin
    rd_word = '0;
    case (rsel)
      RG_IN:   rd_word[PINS-1:0] = in_q_i;
      RG_OUT:  rd_word[PINS-1:0] = out_q_o;
      RG_OE:   rd_word[PINS-1:0] = oe_q_o;
      RG_IE:   rd_word[PINS-1:0] = ie_q_o;
      RG_TRIG: rd_word[PINS-1:0] = trig_q_o;
      RG_AUX:  rd_word[PINS-1:0] = sel_q_o;
      RG_CTRL: rd_word[1:0]      = {pend_q_i, gie_q_o};
      RG_STS:  rd_word[PINS-1:0] = sts_q_i;
      default: rd_word = '0;
    endcase
  end

  assign prdata_o  = (psel_i && hit) ? rd_word : '0;
  assign pslverr_o = access & ~hit;
endmodule

// File: rtl/pin_bank_sampler.sv
module pin_bank_sampler #(
  parameter int PINS        = 8,
  parameter bit USE_EXT_CLK = 1'b0,
  parameter bit EXT_FALL    = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PINS-1:0] pins_i,
  input  logic            ext_clk_i,
  output logic [PINS-1:0] smp_q_o
);
  localparam int SYNC_N = 2;

  logic [PINS-1:0]   pin_s1, pin_s2;
  logic [SYNC_N:0]   ck_pipe;   // two sync stages plus one history stage
  logic              ext_edge, take;
  logic [PINS-1:0]   src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_s1  <= '0;
      pin_s2  <= '0;
      ck_pipe <= '0;
    end else begin
      pin_s1  <= pins_i;
      pin_s2  <= pin_s1;
      ck_pipe <= {ck_pipe[SYNC_N-1:0], ext_clk_i};
    end
  end

  assign ext_edge = EXT_FALL ? (ck_pipe[SYNC_N] & ~ck_pipe[SYNC_N-1])
                             : (ck_pipe[SYNC_N-1] & ~ck_pipe[SYNC_N]);
  assign take     = USE_EXT_CLK ? ext_edge : 1'b1;
  assign src      = USE_EXT_CLK ? pin_s2 : pins_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   smp_q_o <= '0;
    else if (take) smp_q_o <= src;
  end
endmodule

// File: rtl/pin_bank_irq.sv
module pin_bank_irq #(
  parameter int PINS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PINS-1:0] smp_q_i,
  input  logic [PINS-1:0] oe_q_i,
  input  logic [PINS-1:0] ie_q_i,
  input  logic [PINS-1:0] trig_q_i,
  input  logic [PINS-1:0] sts_clr_i,
  input  logic            pend_wr_i,
  input  logic            pend_wval_i,
  input  logic            gie_q_i,
  output logic [PINS-1:0] sts_q_o,
  output logic            pend_q_o,
  output logic            irq_o
);
  logic [PINS-1:0] prev_q, evt;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic rise, fall;
    assign rise   = smp_q_i[i] & ~prev_q[i];
    assign fall   = ~smp_q_i[i] & prev_q[i];
    assign evt[i] = ~oe_q_i[i] & ie_q_i[i] & (trig_q_i[i] ? rise : fall);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      sts_q_o  <= '0;
      pend_q_o <= 1'b0;
    end else begin
      prev_q  <= smp_q_i;
      sts_q_o <= (sts_q_o & ~sts_clr_i) | evt;
      if (|evt)           pend_q_o <= 1'b1;
      else if (pend_wr_i) pend_q_o <= pend_wval_i;
    end
  end

  assign irq_o = gie_q_i & (|sts_q_o);
endmodule

// File: rtl/pin_bank_apb.sv
module pin_bank_apb
  import pin_bank_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int ADDR_W      = 8,
  parameter bit USE_EXT_CLK = 1'b0,
  parameter bit EXT_FALL    = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic [PINS-1:0]   pins_i,
  input  logic              ext_clk_i,
  input  logic [PINS-1:0]   aux_i,
  output logic [PINS-1:0]   pad_out_o,
  output logic [PINS-1:0]   pad_oe_o,
  output logic              irq_o
);
  logic [PINS-1:0] smp_q, sts_q, out_q, oe_q, ie_q, trig_q, sel_q, sts_clr;
  logic            pend_q, gie_q, pend_wr, pend_wval;

  pin_bank_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .psel_i(psel_i), .penable_i(penable_i), .pwrite_i(pwrite_i),
    .paddr_i(paddr_i), .pwdata_i(pwdata_i),
    .prdata_o(prdata_o), .pslverr_o(pslverr_o),
    .in_q_i(smp_q), .sts_q_i(sts_q), .pend_q_i(pend_q),
    .out_q_o(out_q), .oe_q_o(oe_q), .ie_q_o(ie_q), .trig_q_o(trig_q),
    .sel_q_o(sel_q), .gie_q_o(gie_q),
    .sts_clr_o(sts_clr), .pend_wr_o(pend_wr), .pend_wval_o(pend_wval)
  );

  pin_bank_sampler #(.PINS(PINS), .USE_EXT_CLK(USE_EXT_CLK), .EXT_FALL(EXT_FALL)) u_smp (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pins_i(pins_i), .ext_clk_i(ext_clk_i), .smp_q_o(smp_q)
  );

  pin_bank_irq #(.PINS(PINS)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .smp_q_i(smp_q), .oe_q_i(oe_q), .ie_q_i(ie_q), .trig_q_i(trig_q),
    .sts_clr_i(sts_clr), .pend_wr_i(pend_wr), .pend_wval_i(pend_wval),
    .gie_q_i(gie_q),
    .sts_q_o(sts_q), .pend_q_o(pend_q), .irq_o(irq_o)
  );

  // Per-pin source: auxiliary signal or software value
  for (genvar i = 0; i < PINS; i++) begin : g_mux
    assign pad_out_o[i] = sel_q[i] ? aux_i[i] : out_q[i];
  end

  assign pad_oe_o = oe_q;
  assign pready_o = 1'b1;
endmodule

// File: rtl/pin_bank_chk.sv
module pin_bank_chk #(
  parameter int PINS   = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [ADDR_W-1:0] paddr_i,
  input logic [31:0]       pwdata_i,
  input logic              pslverr_o,
  input logic [PINS-1:0]   pad_out_o,
  input logic [PINS-1:0]   pad_oe_o,
  input logic              irq_o,
  input logic [PINS-1:0]   sel_q,
  input logic [PINS-1:0]   oe_q,
  input logic [PINS-1:0]   ie_q,
  input logic [PINS-1:0]   sts_q,
  input logic              gie_q
);
  logic wr_out, wr_sts;
  assign wr_out = psel_i && penable_i && pwrite_i && (paddr_i == ADDR_W'(8'h04));
  assign wr_sts = psel_i && penable_i && pwrite_i && (paddr_i == ADDR_W'(8'h1C));

  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (pad_oe_o == '0 && !irq_o));

  assert_out_follow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_out && sel_q == '0) |=> (pad_out_o == $past(pwdata_i[PINS-1:0])));

  assert_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_q & ~$past(sts_q)) & ($past(oe_q) | ~$past(ie_q))) == '0);

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_sts) |-> ((sts_q & $past(sts_q)) == $past(sts_q)));

  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (gie_q && sts_q != '0));

  assert_err_phase_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> (psel_i && penable_i));
endmodule

bind pin_bank_apb pin_bank_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .psel_i(psel_i), .penable_i(penable_i), .pwrite_i(pwrite_i),
  .paddr_i(paddr_i), .pwdata_i(pwdata_i), .pslverr_o(pslverr_o),
  .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o), .irq_o(irq_o),
  .sel_q(sel_q), .oe_q(oe_q), .ie_q(ie_q), .sts_q(sts_q), .gie_q(gie_q)
);

// File: tb/pin_bank_apb_tb.sv
module pin_bank_apb_tb_top;
  localparam int PINS = 8;
  localparam int AW   = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0]   paddr = '0;
  logic [31:0]     pwdata = '0;
  logic [31:0]     prdata, prdata_x;
  logic            pready, pready_x, pslverr, pslverr_x;
  logic [PINS-1:0] pins = '0, aux = '0;
  logic            ext_clk = 1'b0;
  logic [PINS-1:0] pad_out, pad_oe, pad_out_x, pad_oe_x;
  logic            irq, irq_x;

  int checks = 0;
  int fails  = 0;

  logic [PINS-1:0] m_out = '0, m_oe = '0, m_sel = '0;

  always #2.5 clk = ~clk;

  pin_bank_apb #(.PINS(PINS), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr),
    .pins_i(pins), .ext_clk_i(ext_clk), .aux_i(aux),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  pin_bank_apb #(.PINS(PINS), .ADDR_W(AW), .USE_EXT_CLK(1'b1)) dut_x (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata_x), .pready_o(pready_x), .pslverr_o(pslverr_x),
    .pins_i(pins), .ext_clk_i(ext_clk), .aux_i(aux),
    .pad_out_o(pad_out_x), .pad_oe_o(pad_oe_x), .irq_o(irq_x)
  );

  function automatic logic [PINS-1:0] exp_pad(input logic [PINS-1:0] o, s, a);
    return (s & a) | (~s & o);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a negedge; returns at a negedge
  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d, output logic err);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(posedge clk); @(negedge clk);
    penable = 1'b1;
    #1 err = pslverr;
    @(posedge clk); @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d,
                        output logic [31:0] dx, output logic err, output logic rdy);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    @(posedge clk); @(negedge clk);
    penable = 1'b1;
    #1 d = prdata; dx = prdata_x; err = pslverr; rdy = pready;
    @(posedge clk); @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    #500000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, dx;
    logic        e, r;
    void'($urandom(32'd4711));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1: reset state
    chk("R1 pad_oe", 32'(pad_oe), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    for (int k = 0; k < 8; k++) begin
      apb_rd(8'(k * 4), d, dx, e, r);
      chk("R1 reg readback", d, 32'h0);
    end

    // R10: unmapped addresses
    apb_rd(8'h20, d, dx, e, r);
    chk("R10 err on 0x20", 32'(e), 32'h1);
    chk("R10 pready", 32'(r), 32'h1);
    apb_wr(8'h06, 32'hFF, e);
    chk("R10 err on 0x06", 32'(e), 32'h1);
    apb_rd(8'h04, d, dx, e, r);
    chk("R10 no side effect", d, 32'h0);
    chk("R10 no err on mapped", 32'(e), 32'h0);

    // R2/R3/R4: random register traffic with pad checks
    for (int n = 0; n < 40; n++) begin
      int unsigned kind;
      logic [31:0] wv;
      kind = $urandom_range(1, 5);
      wv   = $urandom();
      aux  = PINS'($urandom());
      apb_wr(8'(kind * 4), wv, e);
      case (kind)
        1: m_out = wv[PINS-1:0];
        2: m_oe  = wv[PINS-1:0];
        5: m_sel = wv[PINS-1:0];
        default: ;
      endcase
      apb_rd(8'(kind * 4), d, dx, e, r);
      chk("R2 readback masked", d, {24'h0, wv[7:0]});
      chk("R3 pad_out mux", 32'(pad_out), 32'(exp_pad(m_out, m_sel, aux)));
      chk("R4 pad_oe", 32'(pad_oe), 32'(m_oe));
    end
    // directed R3 corner: all aux, then none
    apb_wr(8'h14, 32'hFF, e); m_sel = 8'hFF;
    aux = 8'hA5; #1;
    chk("R3 full aux", 32'(pad_out), 32'hA5);
    @(negedge clk);
    apb_wr(8'h14, 32'h0, e); m_sel = 8'h0; #1;
    chk("R3 no aux", 32'(pad_out), 32'(m_out));
    @(negedge clk);
    apb_wr(8'h08, 32'h0, e); m_oe = '0;
    apb_wr(8'h0C, 32'h0, e);

    // R5: input capture and write-ignore
    for (int n = 0; n < 10; n++) begin
      pins = PINS'($urandom());
      wait_cyc(2);
      apb_rd(8'h00, d, dx, e, r);
      chk("R5 input readback", d, 32'(pins));
    end
    apb_wr(8'h00, 32'hFFFF_FFFF, e);
    apb_rd(8'h00, d, dx, e, r);
    chk("R5 write to input ignored", d, 32'(pins));

    // Interrupt setup
    pins = 8'h00; wait_cyc(3);
    apb_wr(8'h0C, 32'hFF, e);
    apb_wr(8'h10, 32'h0F, e);
    apb_wr(8'h1C, 32'hFF, e);
    apb_wr(8'h18, 32'h0, e);

    // R6: polarity
    pins = 8'h01; wait_cyc(3);
    apb_rd(8'h1C, d, dx, e, r);
    chk("R6 rise on bit0", d, 32'h01);
    pins = 8'h80; wait_cyc(3);
    apb_rd(8'h1C, d, dx, e, r);
    chk("R6 no event on wrong polarity", d, 32'h01);
    pins = 8'h00; wait_cyc(3);
    apb_rd(8'h1C, d, dx, e, r);
    chk("R6 fall on bit7", d, 32'h81);

    // R9: gating and pending flag
    chk("R9 irq off with gie 0", 32'(irq), 32'h0);
    apb_rd(8'h18, d, dx, e, r);
    chk("R9 pending set", d, 32'h2);
    apb_wr(8'h18, 32'h3, e);
    chk("R9 irq on", 32'(irq), 32'h1);

    // R8: write-one-to-clear
    apb_wr(8'h1C, 32'h01, e);
    apb_rd(8'h1C, d, dx, e, r);
    chk("R8 partial clear", d, 32'h80);
    chk("R9 irq still on", 32'(irq), 32'h1);
    apb_wr(8'h1C, 32'h80, e);
    chk("R9 irq off when status empty", 32'(irq), 32'h0);
    apb_rd(8'h18, d, dx, e, r);
    chk("R9 pending sticky", d, 32'h3);
    apb_wr(8'h18, 32'h1, e);
    apb_rd(8'h18, d, dx, e, r);
    chk("R9 pending cleared", d, 32'h1);

    // R7: masking by interrupt enable and output enable
    apb_wr(8'h0C, 32'hFD, e);
    apb_wr(8'h08, 32'h04, e);
    apb_wr(8'h10, 32'h06, e);
    pins = 8'h06; wait_cyc(3);
    pins = 8'h00; wait_cyc(3);
    apb_rd(8'h1C, d, dx, e, r);
    chk("R7 masked pins quiet", d, 32'h0);
    chk("R7 irq quiet", 32'(irq), 32'h0);
    apb_wr(8'h0C, 32'hFF, e);
    apb_wr(8'h08, 32'h00, e);
    pins = 8'h02; wait_cyc(3);
    apb_rd(8'h1C, d, dx, e, r);
    chk("R7 enabled pin latches", d, 32'h02);
    apb_wr(8'h1C, 32'hFF, e);

    // R8: event coinciding with clear wins
    apb_wr(8'h10, 32'h08, e);
    pins = 8'h0A;
    apb_wr(8'h1C, 32'h08, e);
    apb_rd(8'h1C, d, dx, e, r);
    chk("R8 event beats clear", d, 32'h08);
    apb_wr(8'h1C, 32'h08, e);
    apb_rd(8'h1C, d, dx, e, r);
    chk("R8 clear alone", d, 32'h0);

    // R11: external clock sampling on second instance
    pins = 8'h5A; wait_cyc(6);
    apb_rd(8'h00, d, dx, e, r);
    chk("R11 main follows pins", d, 32'h5A);
    chk("R11 ext holds without edge", dx, 32'h0);
    ext_clk = 1'b1; wait_cyc(6);
    apb_rd(8'h00, d, dx, e, r);
    chk("R11 ext captures on rise", dx, 32'h5A);
    pins = 8'h33; wait_cyc(4);
    ext_clk = 1'b0; wait_cyc(6);
    apb_rd(8'h00, d, dx, e, r);
    chk("R11 ext ignores fall", dx, 32'h5A);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule